// File: doc/BRIEF.md
# Interrupt Wakeup Mask Accumulator

This block turns edges on a 16-bit external interrupt status word into a word of pending process wakeups. On each capture strobe it compares the upper byte of the status word against the copy kept from the previous capture. Lines that have just gone high become new requests. The block then walks those new requests one per clock, starting at the top.

For each lower line that is set, the block ORs a software-programmed 16-bit wakeup mask into the pending register. The top line is reserved for a periodic process timer. On that line the block decodes the timer's 8-bit interrupt vector. A single-tick code sets the timeout wakeup bit and issues a reset command to the timer. A missed-tick code raises an error pulse instead.

When the walk ends, the block pulses a completion strobe. It also raises a dispatch strobe when wakeups may be delivered, which is only when the external disable count is zero. The consumer clears the pending word with an acknowledge input.

Top module: `wake_mask_accum`

## Requirements
- R1: After reset, `pending` is 0, `scanDone`, `dispatch`, `timerReset`, `tickError` and `busy` are 0, all 16 mask entries read as 0, and the stored previous sample is 0.
- R2: Bits 7..0 of `statusWord` never raise a request; only bits 15..8 are candidates.
- R3: A line is new when it is 1 in the captured word and 0 in the stored copy. Each accepted capture replaces the stored copy. A capture strobe that arrives while `busy` is 1 is ignored entirely.
- R4: Take k as the edge that accepts a capture, and b as the lowest new line in 8..15. When no line is new, `scanDone` is high in the cycle after edge k. Otherwise `busy` is high from edge k until `scanDone` rises after edge k+(16-b), which is one walk step per line from 15 down to b.
- R5: A new line b in 14..8 ORs mask entry 22-b into `pending`, so line 14 uses entry 8 and line 8 uses entry 14. Entries 0..7 and 15 are never used. `pending` keeps its earlier bits between captures.
- R6: A mask entry is written with `maskWrData` at address `maskWrAddr` on a clock edge where `maskWrEn` is 1.
- R7: When line 15 is new and `timerVector` is 8'h00, bit 15 of `pending` is set, and `timerReset` is high for one cycle, in the cycle after the first walk step.
- R8: When line 15 is new and `timerVector` is 8'h06, `tickError` is high for one cycle and `pending` is unchanged by line 15. Any other vector value, including 8'hFF, has no effect.
- R9: When bit 15 of a captured word is 1, the stored copy becomes 0 instead of the captured word, so every set upper line counts as new on the next capture.
- R10: `dispatch` is high in the `scanDone` cycle exactly when `disableCount` is 0 and the updated `pending` is nonzero.
- R11: `pendAck` at a clock edge clears `pending`, but any bits ORed in at that same edge survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | Capture the status word this cycle |
| statusWord | input | 16 | External interrupt status word |
| timerVector | input | 8 | Interrupt vector read from the process timer |
| disableCount | input | 8 | Wakeup disable nesting count |
| maskWrEn | input | 1 | Mask table write enable |
| maskWrAddr | input | 4 | Mask table entry to write |
| maskWrData | input | 16 | Mask value to write |
| pendAck | input | 1 | Clear the pending wakeup word |
| pending | output | 16 | Accumulated pending wakeups |
| scanDone | output | 1 | One-cycle end-of-walk strobe |
| dispatch | output | 1 | Wakeup delivery should run |
| timerReset | output | 1 | Reset command to the process timer |
| tickError | output | 1 | Timer reported two or more missed ticks |
| busy | output | 1 | Walk in progress; captures are ignored |

## Verification
The bench reads a line-14 request before any mask is written, which exposes a mask table that does not reset to zero. It then writes nonzero values into the unused entries 0..7 and 15, so an off-by-one mask index, or a mask ORed at the top step, shows up as extra `pending` bits. It captures the same word twice and checks that the second capture raises nothing, which catches level-triggered sampling. A capture injected mid-walk must leave the stored copy untouched, or a later capture would report the wrong new lines. Repeated line-15 captures must fire every time, because the stored copy is cleared. An acknowledge held through a whole walk must leave exactly the last ORed mask in `pending`, or the clear-versus-OR priority is wrong. Latency is checked on every capture, which catches a walk that stops too early or too late.

// File: rtl/wma_pkg.sv
package wma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TOP,
    ST_LOW
  } scanState_t;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic load;      // capture status, load walk register
    logic shift;     // advance walk register by one line
    logic orMask;    // OR selected mask entry into pending
    logic timerSet;  // set timeout wakeup bit
    logic finish;    // walk ends at this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/wma_timer_decode.sv
module wma_timer_decode #(
  parameter int VEC_W     = 8,
  parameter int TICK_CODE = 8'h00,
  parameter int ERR_CODE  = 8'h06
) (
  input  logic [VEC_W-1:0] timerVector,
  output logic             tickValid,
  output logic             tickErr
);

  localparam logic [VEC_W-1:0] TICK_VEC = VEC_W'(TICK_CODE);
  localparam logic [VEC_W-1:0] ERR_VEC  = VEC_W'(ERR_CODE);

  // Every code other than these two (idle code included) is inert
  assign tickValid = (timerVector == TICK_VEC);
  assign tickErr   = (timerVector == ERR_VEC);

endmodule

// File: rtl/wma_mask_table.sv
module wma_mask_table #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] entryQ [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ[e] <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(e))) begin
        entryQ[e] <= wrData;
      end
    end
  end

  assign rdData = entryQ[rdAddr];

endmodule

// File: rtl/wma_datapath.sv
module wma_datapath
  import wma_pkg::*;
#(
  parameter int STATUS_W     = 16,
  parameter int REQ_W        = 8,
  parameter int MASK_ENTRIES = 16,
  localparam int IDX_W       = $clog2(MASK_ENTRIES),
  localparam int LOW_W       = STATUS_W - REQ_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [IDX_W-1:0]    idx,
  input  logic [STATUS_W-1:0] statusWord,
  input  logic                maskWrEn,
  input  logic [IDX_W-1:0]    maskWrAddr,
  input  logic [STATUS_W-1:0] maskWrData,
  input  logic                pendAck,
  output logic                curBit,
  output logic                restZero,
  output logic                newZero,
  output logic                pendNextNz,
  output logic [STATUS_W-1:0] pending
);

  localparam logic [STATUS_W-1:0] TIMEOUT_BIT = {1'b1, {(STATUS_W-1){1'b0}}};

  logic [REQ_W-1:0]    prevReq;
  logic [REQ_W-1:0]    scanReg;
  logic [REQ_W-1:0]    upperNow;
  logic [REQ_W-1:0]    newReqNow;
  logic [STATUS_W-1:0] maskRd;
  logic [STATUS_W-1:0] orTerm;
  logic [STATUS_W-1:0] pendNext;
  logic                unusedLowBits;

  // Lower status byte carries no requests
  assign unusedLowBits = ^statusWord[LOW_W-1:0];

  assign upperNow  = statusWord[STATUS_W-1 -: REQ_W];
  assign newReqNow = upperNow & ~prevReq;
  assign newZero   = (newReqNow == '0);

  assign curBit   = scanReg[REQ_W-1];
  assign restZero = (scanReg[REQ_W-2:0] == '0);

  wma_mask_table #(
    .ENTRIES (MASK_ENTRIES),
    .DATA_W  (STATUS_W)
  ) u_maskTable (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (maskWrEn),
    .wrAddr (maskWrAddr),
    .wrData (maskWrData),
    .rdAddr (idx),
    .rdData (maskRd)
  );

  always_comb begin
    orTerm = '0;
    if (strb.orMask)   orTerm = orTerm | maskRd;
    if (strb.timerSet) orTerm = orTerm | TIMEOUT_BIT;
    pendNext = (pendAck ? '0 : pending) | orTerm;
  end

  assign pendNextNz = (pendNext != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= '0;
      scanReg <= '0;
      pending <= '0;
    end else begin
      pending <= pendNext;
      if (strb.load) begin
        // A still-asserted timer line forces full re-evaluation next time
        prevReq <= statusWord[STATUS_W-1] ? '0 : upperNow;
        scanReg <= newReqNow;
      end else if (strb.shift) begin
        scanReg <= {scanReg[REQ_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/wma_ctrl.sv
module wma_ctrl
  import wma_pkg::*;
#(
  parameter int MASK_ENTRIES = 16,
  parameter int MASK_BASE    = 8,
  parameter int VEC_W        = 8,
  parameter int CNT_W        = 8,
  parameter int TICK_CODE    = 8'h00,
  parameter int ERR_CODE     = 8'h06,
  localparam int IDX_W       = $clog2(MASK_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic             curBit,
  input  logic             restZero,
  input  logic             newZero,
  input  logic             pendNextNz,
  input  logic [VEC_W-1:0] timerVector,
  input  logic [CNT_W-1:0] disableCount,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             scanDone,
  output logic             dispatch,
  output logic             timerReset,
  output logic             tickError
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MASK_BASE - 1);

  scanState_t state, nextState;
  logic       tickValid;
  logic       tickErr;
  logic       errStep;

  wma_timer_decode #(
    .VEC_W     (VEC_W),
    .TICK_CODE (TICK_CODE),
    .ERR_CODE  (ERR_CODE)
  ) u_timerDecode (
    .timerVector (timerVector),
    .tickValid   (tickValid),
    .tickErr     (tickErr)
  );

  always_comb begin
    strb      = '0;
    errStep   = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (sampleStrobe) begin
          strb.load = 1'b1;
          if (newZero) strb.finish = 1'b1;
          else         nextState   = ST_TOP;
        end
      end
      ST_TOP: begin
        strb.shift    = 1'b1;
        strb.timerSet = curBit && tickValid;
        errStep       = curBit && tickErr;
        if (restZero) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          nextState   = ST_LOW;
        end
      end
      ST_LOW: begin
        strb.shift  = 1'b1;
        strb.orMask = curBit;
        if (restZero) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      scanDone   <= 1'b0;
      dispatch   <= 1'b0;
      timerReset <= 1'b0;
      tickError  <= 1'b0;
    end else begin
      state      <= nextState;
      scanDone   <= strb.finish;
      dispatch   <= strb.finish && (disableCount == '0) && pendNextNz;
      timerReset <= strb.timerSet;
      tickError  <= errStep;
      if (strb.load)       idx <= IDX_TOP;
      else if (strb.shift) idx <= idx + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wake_mask_accum.sv
module wake_mask_accum
  import wma_pkg::*;
#(
  parameter int STATUS_W     = 16,
  parameter int REQ_W        = 8,
  parameter int MASK_ENTRIES = 16,
  parameter int MASK_BASE    = 8,
  parameter int VEC_W        = 8,
  parameter int CNT_W        = 8,
  parameter int TICK_CODE    = 8'h00,
  parameter int ERR_CODE     = 8'h06,
  localparam int IDX_W       = $clog2(MASK_ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStrobe,
  input  logic [STATUS_W-1:0] statusWord,
  input  logic [VEC_W-1:0]    timerVector,
  input  logic [CNT_W-1:0]    disableCount,
  input  logic                maskWrEn,
  input  logic [IDX_W-1:0]    maskWrAddr,
  input  logic [STATUS_W-1:0] maskWrData,
  input  logic                pendAck,
  output logic [STATUS_W-1:0] pending,
  output logic                scanDone,
  output logic                dispatch,
  output logic                timerReset,
  output logic                tickError,
  output logic                busy
);

  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] idx;
  logic             curBit;
  logic             restZero;
  logic             newZero;
  logic             pendNextNz;

  wma_ctrl #(
    .MASK_ENTRIES (MASK_ENTRIES),
    .MASK_BASE    (MASK_BASE),
    .VEC_W        (VEC_W),
    .CNT_W        (CNT_W),
    .TICK_CODE    (TICK_CODE),
    .ERR_CODE     (ERR_CODE)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .curBit       (curBit),
    .restZero     (restZero),
    .newZero      (newZero),
    .pendNextNz   (pendNextNz),
    .timerVector  (timerVector),
    .disableCount (disableCount),
    .strb         (strb),
    .idx          (idx),
    .busy         (busy),
    .scanDone     (scanDone),
    .dispatch     (dispatch),
    .timerReset   (timerReset),
    .tickError    (tickError)
  );

  wma_datapath #(
    .STATUS_W     (STATUS_W),
    .REQ_W        (REQ_W),
    .MASK_ENTRIES (MASK_ENTRIES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .idx        (idx),
    .statusWord (statusWord),
    .maskWrEn   (maskWrEn),
    .maskWrAddr (maskWrAddr),
    .maskWrData (maskWrData),
    .pendAck    (pendAck),
    .curBit     (curBit),
    .restZero   (restZero),
    .newZero    (newZero),
    .pendNextNz (pendNextNz),
    .pending    (pending)
  );

endmodule

// File: rtl/wma_checker.sv
module wma_checker #(
  parameter int STATUS_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                pendAck,
  input logic [STATUS_W-1:0] pending,
  input logic                scanDone,
  input logic                dispatch,
  input logic                timerReset,
  input logic                tickError,
  input logic                busy
);

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !busy);  // R4

  AST_DISPATCH_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    dispatch |-> (scanDone && (pending != '0)));  // R10

  AST_PENDING_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    !pendAck |=> ((pending & $past(pending)) == $past(pending)));  // R5

  AST_IDLE_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !pendAck) |=> $stable(pending));  // R11

  AST_TIMER_SETS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    timerReset |-> pending[STATUS_W-1]);  // R7

  AST_TIMER_CODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(timerReset && tickError));  // R8

endmodule

bind wake_mask_accum wma_checker #(.STATUS_W(STATUS_W)) u_wmaChecker (
  .clk        (clk),
  .rstN       (rstN),
  .pendAck    (pendAck),
  .pending    (pending),
  .scanDone   (scanDone),
  .dispatch   (dispatch),
  .timerReset (timerReset),
  .tickError  (tickError),
  .busy       (busy)
);

// File: tb/test_wake_mask_accum.sv
module test_wake_mask_accum;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] pend;
    logic        disp;
    logic        rst;
    logic        err;
    int          doneCyc;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] statusWord = '0;
  logic [7:0]  timerVector = 8'hFF;
  logic [7:0]  disableCount = '0;
  logic        maskWrEn = 1'b0;
  logic [3:0]  maskWrAddr = '0;
  logic [15:0] maskWrData = '0;
  logic        pendAck = 1'b0;
  logic [15:0] pending;
  logic        scanDone, dispatch, timerReset, tickError, busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  expItem_t expQ[$];
  logic [15:0] maskM [16];
  logic [7:0]  prevM = '0;
  logic [15:0] pendM = '0;
  bit sawRst = 0, sawErr = 0;

  wake_mask_accum i_wake_mask_accum (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .statusWord(statusWord),
    .timerVector(timerVector), .disableCount(disableCount), .maskWrEn(maskWrEn),
    .maskWrAddr(maskWrAddr), .maskWrData(maskWrData), .pendAck(pendAck),
    .pending(pending), .scanDone(scanDone), .dispatch(dispatch),
    .timerReset(timerReset), .tickError(tickError), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each completed walk against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (timerReset) sawRst = 1;
      if (tickError)  sawErr = 1;
      if (scanDone) begin
        if (expQ.size() == 0) begin
          check(0, "R4", "unexpected scanDone", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(pending == it.pend, "R5", "pending", pending, it.pend);
          check(dispatch == it.disp, "R10", "dispatch", dispatch, it.disp);
          check(cyc == it.doneCyc, "R4", "done cycle", cyc, it.doneCyc);
          check(sawRst == it.rst, "R7", "timerReset", sawRst, it.rst);
          check(sawErr == it.err, "R8", "tickError", sawErr, it.err);
        end
        sawRst = 0;
        sawErr = 0;
      end
    end
  end

  task automatic writeMask(input int addr, input logic [15:0] data);
    @(negedge clk);
    maskWrEn = 1; maskWrAddr = 4'(addr); maskWrData = data;
    @(negedge clk);
    maskWrEn = 0;
    maskM[addr] = data;  // R6
  endtask

  task automatic ackPulse();
    @(negedge clk); pendAck = 1;
    @(negedge clk); pendAck = 0;
    pendM = '0;
    check(pending == 16'h0, "R11", "pending after ack", pending, 0);
  endtask

  // Driver: predicts the result, pushes it, then drives one capture
  task automatic doSample(input logic [15:0] st, input logic [7:0] vec,
                          input logic [7:0] dc, input bit junk, input bit ackDuring);
    expItem_t it;
    logic [7:0] nr;
    int lowB;
    int s;
    nr = st[15:8] & ~prevM;
    prevM = st[15] ? 8'h00 : st[15:8];
    lowB = -1;
    for (int b = 8; b < 16; b++) if (lowB < 0 && nr[b-8]) lowB = b;
    s = (lowB < 0) ? 0 : 16 - lowB;
    it.rst = nr[7] && (vec == 8'h00);
    it.err = nr[7] && (vec == 8'h06);
    if (ackDuring) begin
      if (lowB == 15) pendM = it.rst ? 16'h8000 : 16'h0000;
      else if (lowB >= 8) pendM = maskM[22-lowB];
    end else begin
      if (it.rst) pendM = pendM | 16'h8000;
      for (int b = 8; b < 15; b++) if (nr[b-8]) pendM = pendM | maskM[22-b];
    end
    it.pend = pendM;
    it.disp = (dc == 0) && (pendM != 0);
    @(negedge clk);
    statusWord = st; timerVector = vec; disableCount = dc; sampleStrobe = 1;
    it.doneCyc = cyc + 1 + s;
    expQ.push_back(it);
    @(negedge clk);
    sampleStrobe = 0;
    if (s > 0) check(busy == 1'b1, "R4", "busy during walk", busy, 1);
    if (junk && s >= 2) begin
      statusWord = ~st; sampleStrobe = 1;  // R3: must be ignored
      @(negedge clk);
      sampleStrobe = 0;
    end
    if (ackDuring) pendAck = 1;
    while (!scanDone) @(negedge clk);
    pendAck = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) maskM[e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(pending == 0, "R1", "pending", pending, 0);
    check({scanDone, dispatch, timerReset, tickError, busy} == 0, "R1", "flags",
          {scanDone, dispatch, timerReset, tickError, busy}, 0);
    // R1 mask table zero: line 14 before any write
    doSample(16'h4000, 8'hFF, 8'd0, 0, 0);
    // R6 program table; unused entries get poison values
    for (int e = 0; e < 16; e++)
      writeMask(e, (e >= 8 && e <= 14) ? (16'h0011 << (e - 8)) : 16'h7FFF);
    // R2 low byte only
    doSample(16'h00FF, 8'hFF, 8'd0, 0, 0);
    // R5 several lines
    doSample(16'h5500, 8'hFF, 8'd0, 0, 0);
    // R3 same word again: nothing new
    doSample(16'h5500, 8'hFF, 8'd0, 0, 0);
    ackPulse();
    // R10 disabled; R3 capture during walk ignored
    doSample(16'h7F00, 8'hFF, 8'd3, 1, 0);
    doSample(16'h0000, 8'hFF, 8'd0, 0, 0);
    ackPulse();
    // R7 timer tick, R9 stored copy cleared
    doSample(16'h8000, 8'h00, 8'd0, 0, 0);
    // R8 missed ticks (line new again because of R9)
    doSample(16'h8000, 8'h06, 8'd0, 0, 0);
    ackPulse();
    // R8 idle code
    doSample(16'h8000, 8'hFF, 8'd0, 0, 0);
    // R11 ack held across walk: ORs win
    doSample(16'hC000, 8'h00, 8'd0, 0, 1);
    // R5 lowest line, longest walk
    doSample(16'h0100, 8'hFF, 8'd0, 0, 0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4", "outstanding walks", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule